// File: doc/BRIEF.md
# MSI Interrupt Remapping Translator

This block sits in the path of 32-bit message-signalled interrupt writes that devices send toward the interrupt controller. When remapping is enabled and a write targets the interrupt address window (upper twelve address bits equal to 0xFEE), the block treats the address as a remappable-format handle. It builds a table index from the handle and, if asked, a subhandle taken from the write data. It fetches the 128-bit table entry over a memory read request/response channel, checks the entry, and sends out a rewritten standard-format interrupt write.

Writes outside the window, and all writes while remapping is off, are forwarded unchanged. A write that fails any check is dropped, and `err_pulse` is raised for one cycle. The block handles one write at a time. The table base, entry count and enable are live configuration inputs, sampled when a write is accepted.

Top module: `msi_remap_xlat`

## Requirements
- R1: A write accepted while `cfg_enable` is 0, or whose address bits 31:20 differ from 0xFEE, is emitted on the output with identical address and data, and no memory read is issued.
- R2: An intercepted write whose byte strobe `in_strb` is not 4'b1111 is dropped with one `err_pulse`, and no memory read is issued.
- R3: An intercepted full-word write with address bit 4 equal to 0 (legacy format) is dropped with one `err_pulse`, and no memory read is issued.
- R4: The table index is the 16-bit handle {addr[2], addr[19:5]}, plus data[15:0] when addr[3] is 1, computed without wrap in 17 bits. An index greater than or equal to `cfg_count` drops the write with one `err_pulse` and no memory read.
- R5: The entry is read as two 64-bit words, one request at a time: the low word at {cfg_tbl_base,4'b0} + index*16, then the high word at that address + 8.
- R6: If bit 0 (present) of the low word is 0, the write is dropped with one `err_pulse`, and the high word is not read.
- R7: If bits 15:0 of the high word differ from `in_src_id`, the write is dropped with one `err_pulse`.
- R8: The output address is 0xFEE00000, with low-word bit 2 (destination mode) at bit 2, bit 3 (redirection hint) at bit 3, and low-word bits 39:32 (destination) at bits 19:12.
- R9: The output data holds low-word bits 23:16 (vector) at bits 7:0, bits 7:5 (delivery mode) at bits 10:8, a constant 1 at bit 14 and bit 4 (trigger mode) at bit 15. All other data bits are 0.
- R10: A read response with `mrs_err` set drops the write with one `err_pulse`, and no further read is issued for that write.
- R11: `in_ready` is low from the cycle after a non-dropped write is accepted until its output write is taken. While `out_valid` is high and `out_ready` is low, the output address and data do not change.
- R12: After reset, `in_ready` is 1 and `out_valid`, `mrd_valid` and `err_pulse` are 0. Each dropped write raises `err_pulse` for exactly one cycle, and a write that is forwarded or remapped raises none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming interrupt write valid |
| in_ready | output | 1 | Block idle and able to accept a write |
| in_addr | input | 32 | Incoming write address |
| in_data | input | 32 | Incoming write data |
| in_strb | input | 4 | Incoming byte strobes |
| in_src_id | input | 16 | Requester bus/device/function |
| cfg_enable | input | 1 | Remapping enable |
| cfg_tbl_base | input | MEM_AW-4 | Table base in 16-byte units |
| cfg_count | input | 17 | Number of table entries |
| mrd_valid | output | 1 | Memory read request valid |
| mrd_ready | input | 1 | Memory read request accepted |
| mrd_addr | output | MEM_AW | Memory read byte address |
| mrs_valid | input | 1 | Memory read response valid |
| mrs_data | input | 64 | Memory read response word |
| mrs_err | input | 1 | Memory read response error |
| out_valid | output | 1 | Outgoing interrupt write valid |
| out_ready | input | 1 | Outgoing write accepted |
| out_addr | output | 32 | Outgoing write address |
| out_data | output | 32 | Outgoing write data |
| err_pulse | output | 1 | One-cycle flag for a dropped write |

## Verification
Some properties are checked by assertions on every cycle:
- the output stays stable under backpressure;
- a read request stays stable until it is taken;
- a read request and an output write are never pending together;
- a high-word read happens only after a present low word;
- the busy handshake holds;
- every remapped address stays inside the interrupt window.

Other behaviour only the bench scenarios can show:
- the exact index arithmetic with subhandles and handle bit 15;
- which check drops a write, and how many reads happen before it;
- the bit placement of the rebuilt address and data;
- the one-cycle error flag at each drop point, including injected response errors.

// File: rtl/msi_remap_pkg.sv
// Shared types and constants for the MSI remapping translator.
// Assumes 32-bit interrupt writes and 128-bit table entries read as two 64-bit words.
package msi_remap_pkg;

    localparam int HANDLE_W = 16;
    localparam int INDEX_W  = HANDLE_W + 1;
    localparam int SID_W    = 16;
    localparam logic [11:0] MSI_WINDOW = 12'hFEE;
    localparam logic [31:0] MSI_BASE   = 32'hFEE0_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO_REQ,
        ST_LO_RSP,
        ST_HI_REQ,
        ST_HI_RSP,
        ST_EMIT
    } walk_state_t;

    typedef enum logic [1:0] {
        CLS_PASS,
        CLS_DROP,
        CLS_FETCH
    } req_class_t;

    // Fields of the low entry word that the rebuilt interrupt needs.
    typedef struct packed {
        logic [7:0] dest;
        logic [7:0] vector;
        logic [2:0] dlv;
        logic       trig;
        logic       rhint;
        logic       dmode;
    } entry_fields_t;

endpackage

// File: rtl/msi_req_decode.sv
// Classifies an incoming interrupt write and computes its table index.
// Purely combinational. Assumes the caller samples the result only while idle.
module msi_req_decode
    import msi_remap_pkg::*;
(
    input  logic [31:2]        addr_w,
    input  logic [15:0]        data_sub,
    input  logic [3:0]         strb,
    input  logic               enable,
    input  logic [INDEX_W-1:0] count,
    output req_class_t         cls,
    output logic [INDEX_W-1:0] index
);

    logic               in_window;
    logic [HANDLE_W-1:0] handle;

    // Build the handle from the split address fields.
    always_comb begin
        in_window = (addr_w[31:20] == MSI_WINDOW);
        handle    = {addr_w[2], addr_w[19:5]};
    end

    // Add the optional subhandle without wrapping.
    always_comb begin
        index = {1'b0, handle} + (addr_w[3] ? {1'b0, data_sub} : '0);
    end

    // Decide between forwarding, dropping and fetching.
    always_comb begin
        if (!enable || !in_window) begin
            cls = CLS_PASS;
        end else if (strb != 4'b1111) begin
            cls = CLS_DROP;
        end else if (!addr_w[4]) begin
            cls = CLS_DROP;
        end else if (index >= count) begin
            cls = CLS_DROP;
        end else begin
            cls = CLS_FETCH;
        end
    end

endmodule

// File: rtl/msi_irte_walker.sv
// Sequences one interrupt write at a time: accept, fetch the two entry words,
// check the entry, hold the result until the output takes it.
// Assumes read responses arrive in order, one per accepted request.
module msi_irte_walker
    import msi_remap_pkg::*;
#(
    parameter int MEM_AW = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  req_class_t          cls,
    input  logic [INDEX_W-1:0]  index,
    input  logic [31:0]         in_addr,
    input  logic [31:0]         in_data,
    input  logic [SID_W-1:0]    in_src_id,
    input  logic [MEM_AW-5:0]   tbl_base,
    output logic                in_ready,
    output logic                mrd_valid,
    input  logic                mrd_ready,
    output logic [MEM_AW-1:0]   mrd_addr,
    input  logic                mrs_valid,
    input  logic [63:0]         mrs_data,
    input  logic                mrs_err,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                pass_q,
    output logic [31:0]         pass_addr_q,
    output logic [31:0]         pass_data_q,
    output entry_fields_t       fields_q,
    output logic                err_q
);

    localparam int SLOT_W = MEM_AW - 4;

    walk_state_t       state;
    logic [SLOT_W-1:0] slot_q;
    logic [SID_W-1:0]  sid_q;
    logic [SLOT_W-1:0] slot_next;

    // Entry slot number = base slot + index.
    always_comb begin
        slot_next = tbl_base + SLOT_W'(index);
    end

    // Handshake outputs derived from the state.
    always_comb begin
        in_ready  = (state == ST_IDLE);
        mrd_valid = (state == ST_LO_REQ) || (state == ST_HI_REQ);
        out_valid = (state == ST_EMIT);
        mrd_addr  = {slot_q, (state == ST_HI_REQ), 3'b000};
    end

    // Main sequencer with the drop flag and the latched results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            err_q       <= 1'b0;
            pass_q      <= 1'b0;
            pass_addr_q <= '0;
            pass_data_q <= '0;
            fields_q    <= '0;
            slot_q      <= '0;
            sid_q       <= '0;
        end else begin
            err_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        case (cls)
                            CLS_PASS: begin
                                pass_q      <= 1'b1;
                                pass_addr_q <= in_addr;
                                pass_data_q <= in_data;
                                state       <= ST_EMIT;
                            end
                            CLS_FETCH: begin
                                pass_q <= 1'b0;
                                slot_q <= slot_next;
                                sid_q  <= in_src_id;
                                state  <= ST_LO_REQ;
                            end
                            default: err_q <= 1'b1;
                        endcase
                    end
                end
                ST_LO_REQ: if (mrd_ready) state <= ST_LO_RSP;
                ST_LO_RSP: begin
                    if (mrs_valid) begin
                        if (mrs_err || !mrs_data[0]) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            fields_q.dest   <= mrs_data[39:32];
                            fields_q.vector <= mrs_data[23:16];
                            fields_q.dlv    <= mrs_data[7:5];
                            fields_q.trig   <= mrs_data[4];
                            fields_q.rhint  <= mrs_data[3];
                            fields_q.dmode  <= mrs_data[2];
                            state           <= ST_HI_REQ;
                        end
                    end
                end
                ST_HI_REQ: if (mrd_ready) state <= ST_HI_RSP;
                ST_HI_RSP: begin
                    if (mrs_valid) begin
                        if (mrs_err || (mrs_data[SID_W-1:0] != sid_q)) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_EMIT;
                        end
                    end
                end
                ST_EMIT: if (out_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a pending read request keeps its address until taken.
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));

    // R5: reads and output writes never overlap.
    a_r5_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
        !(mrd_valid && out_valid));

    // R6: the high word is requested only for a present entry.
    a_r6_hi_after_present: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_valid && mrd_addr[3] |-> $past(mrs_valid && mrs_data[0]) || $past(mrd_valid && mrd_addr[3]));

    // R11: a non-dropped accept makes the block busy next cycle.
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready || err_q);

    // R12: a drop always leaves the block idle.
    a_r12_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> in_ready && !out_valid);

endmodule

// File: rtl/msi_compose.sv
// Rebuilds a standard-format interrupt address and data word from entry fields.
// Purely combinational.
module msi_compose
    import msi_remap_pkg::*;
(
    input  entry_fields_t fields,
    output logic [31:0]   msi_addr,
    output logic [31:0]   msi_data
);

    // Place destination, hint and mode into the window address.
    always_comb begin
        msi_addr = MSI_BASE | {12'h000, fields.dest, 8'h00, fields.rhint, fields.dmode, 2'b00};
    end

    // Place vector, delivery, level-assert and trigger into the data word.
    always_comb begin
        msi_data = {16'h0000, fields.trig, 1'b1, 3'b000, fields.dlv, fields.vector};
    end

endmodule

// File: rtl/msi_remap_xlat.sv
// Top of the MSI remapping translator: decode, entry walk, rebuild, output select.
// Assumes configuration stays stable while a write is in flight.
module msi_remap_xlat
    import msi_remap_pkg::*;
#(
    parameter int MEM_AW = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_addr,
    input  logic [31:0]       in_data,
    input  logic [3:0]        in_strb,
    input  logic [15:0]       in_src_id,
    input  logic              cfg_enable,
    input  logic [MEM_AW-5:0] cfg_tbl_base,
    input  logic [16:0]       cfg_count,
    output logic              mrd_valid,
    input  logic              mrd_ready,
    output logic [MEM_AW-1:0] mrd_addr,
    input  logic              mrs_valid,
    input  logic [63:0]       mrs_data,
    input  logic              mrs_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_addr,
    output logic [31:0]       out_data,
    output logic              err_pulse
);

    req_class_t         cls;
    logic [INDEX_W-1:0] index;
    logic               pass_q;
    logic [31:0]        pass_addr_q;
    logic [31:0]        pass_data_q;
    entry_fields_t      fields_q;
    logic [31:0]        new_addr;
    logic [31:0]        new_data;

    msi_req_decode u_decode (
        .addr_w   (in_addr[31:2]),
        .data_sub (in_data[15:0]),
        .strb     (in_strb),
        .enable   (cfg_enable),
        .count    (cfg_count),
        .cls      (cls),
        .index    (index)
    );

    msi_irte_walker #(.MEM_AW(MEM_AW)) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .cls         (cls),
        .index       (index),
        .in_addr     (in_addr),
        .in_data     (in_data),
        .in_src_id   (in_src_id),
        .tbl_base    (cfg_tbl_base),
        .in_ready    (in_ready),
        .mrd_valid   (mrd_valid),
        .mrd_ready   (mrd_ready),
        .mrd_addr    (mrd_addr),
        .mrs_valid   (mrs_valid),
        .mrs_data    (mrs_data),
        .mrs_err     (mrs_err),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .pass_q      (pass_q),
        .pass_addr_q (pass_addr_q),
        .pass_data_q (pass_data_q),
        .fields_q    (fields_q),
        .err_q       (err_pulse)
    );

    msi_compose u_compose (
        .fields   (fields_q),
        .msi_addr (new_addr),
        .msi_data (new_data)
    );

    // Forwarded writes keep their words; remapped ones take the rebuilt words.
    always_comb begin
        out_addr = pass_q ? pass_addr_q : new_addr;
        out_data = pass_q ? pass_data_q : new_data;
    end

    // R11: output held steady under backpressure.
    a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data));

    // R8: a remapped write always lands in the interrupt window.
    a_r8_window: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !pass_q |-> out_addr[31:20] == MSI_WINDOW && out_addr[1:0] == 2'b00);

    // R9: a remapped data word always asserts level and clears the spare bits.
    a_r9_level: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !pass_q |-> out_data[14] && out_data[31:16] == 16'h0 && out_data[13:11] == 3'b000);

endmodule

// File: tb/sim_msi_remap_xlat.sv
module sim_msi_remap_xlat;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_AW     = 48;
    localparam int TBL_N      = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_addr = '0;
    logic [31:0]       in_data = '0;
    logic [3:0]        in_strb = 4'hF;
    logic [15:0]       in_src_id = '0;
    logic              cfg_enable = 1'b0;
    logic [MEM_AW-5:0] cfg_tbl_base = '0;
    logic [16:0]       cfg_count = '0;
    logic              mrd_valid;
    logic              mrd_ready = 1'b0;
    logic [MEM_AW-1:0] mrd_addr;
    logic              mrs_valid = 1'b0;
    logic [63:0]       mrs_data = '0;
    logic              mrs_err = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [31:0]       out_addr;
    logic [31:0]       out_data;
    logic              err_pulse;

    int n_checks = 0;
    int n_fail = 0;

    logic [63:0] tlo [TBL_N];
    logic [63:0] thi [TBL_N];

    // memory model and monitor state
    logic        rsp_pending = 1'b0;
    logic [63:0] rsp_d = '0;
    logic        rsp_e = 1'b0;
    int          rd_n = 0;
    int          inj = 0;
    logic [63:0] exp_ent = '0;
    int          exp_idx = 0;
    int          err_n = 0;
    bit          got_out = 0;
    bit          held = 0;
    bit          bp_mode = 0;
    logic [31:0] cap_addr = '0, cap_data = '0, hold_addr = '0, hold_data = '0;

    msi_remap_xlat #(.MEM_AW(MEM_AW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .in_strb(in_strb), .in_src_id(in_src_id),
        .cfg_enable(cfg_enable), .cfg_tbl_base(cfg_tbl_base), .cfg_count(cfg_count),
        .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
        .mrs_valid(mrs_valid), .mrs_data(mrs_data), .mrs_err(mrs_err),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_data(out_data), .err_pulse(err_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_lo(input int idx);
        return (idx < TBL_N) ? tlo[idx] : 64'h0;
    endfunction

    function automatic logic [63:0] entry_hi(input int idx);
        return (idx < TBL_N) ? thi[idx] : 64'h0;
    endfunction

    // kind: 0 forward, 1 drop, 2 remap
    task automatic predict(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                           input logic [15:0] src, output int kind, output int reads,
                           output logic [31:0] ea, output logic [31:0] ed, output string tag);
        logic [16:0] idx;
        logic [63:0] lo, hi;
        idx = {1'b0, a[2], a[19:5]} + (a[3] ? {1'b0, d[15:0]} : 17'h0);
        exp_idx = int'(idx);
        ea = a; ed = d; reads = 0; kind = 1;
        if (!cfg_enable || a[31:20] != 12'hFEE) begin kind = 0; tag = "R1"; end
        else if (s != 4'hF) tag = "R2";
        else if (!a[4]) tag = "R3";
        else if (idx >= cfg_count) tag = "R4";
        else begin
            lo = entry_lo(exp_idx);
            hi = entry_hi(exp_idx);
            reads = 1;
            if (inj == 1) tag = "R10";
            else if (!lo[0]) tag = "R6";
            else begin
                reads = 2;
                if (inj == 2) tag = "R10";
                else if (hi[15:0] != src) tag = "R7";
                else begin
                    kind = 2; tag = "R8";
                    ea = 32'hFEE0_0000 | (32'(lo[39:32]) << 12) | (32'(lo[3]) << 3) | (32'(lo[2]) << 2);
                    ed = 32'(lo[23:16]) | (32'(lo[7:5]) << 8) | (32'h1 << 14) | (32'(lo[4]) << 15);
                end
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rsp_pending) begin
            mrs_valid = 1'b1; mrs_data = rsp_d; mrs_err = rsp_e; rsp_pending = 1'b0;
        end else begin
            mrs_valid = 1'b0; mrs_err = 1'b0;
        end
        mrd_ready = ($urandom % 4) != 0;
        if (mrd_valid && mrd_ready) begin
            chk("R5 read address", 64'(mrd_addr), exp_ent + 64'(rd_n * 8));
            rsp_d = (rd_n == 0) ? entry_lo(exp_idx) : entry_hi(exp_idx);
            rsp_e = (inj == rd_n + 1);
            rd_n++;
            rsp_pending = 1'b1;
        end
        out_ready = bp_mode ? ($urandom % 2) == 1 : 1'b1;
        if (out_valid) begin
            if (held) begin
                chk("R11 held address", 64'(out_addr), 64'(hold_addr));
                chk("R11 held data", 64'(out_data), 64'(hold_data));
            end
            if (out_ready) begin
                got_out = 1; cap_addr = out_addr; cap_data = out_data; held = 0;
            end else begin
                held = 1; hold_addr = out_addr; hold_data = out_data;
            end
        end
        if (err_pulse) err_n++;
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                       input logic [15:0] src);
        int kind, reads;
        logic [31:0] ea, ed;
        string tag;
        predict(a, d, s, src, kind, reads, ea, ed, tag);
        exp_ent = {16'h0, cfg_tbl_base, 4'h0} + 64'(exp_idx) * 64'd16;
        rd_n = 0; err_n = 0; got_out = 0; held = 0;
        in_addr = a; in_data = d; in_strb = s; in_src_id = src; in_valid = 1'b1;
        chk("R11 ready when idle", 64'(in_ready), 64'h1);
        tick();
        in_valid = 1'b0;
        if (kind != 1) chk("R11 busy after accept", 64'(in_ready), 64'h0);
        for (int k = 0; k < 80 && !(got_out || err_n > 0); k++) tick();
        repeat (3) tick();
        chk({tag, " output taken"}, 64'(got_out), 64'(kind != 1));
        chk({tag, " R12 error pulses"}, 64'(err_n), 64'(kind == 1));
        chk({tag, " read count"}, 64'(rd_n), 64'(reads));
        if (kind == 0) begin
            chk("R1 address", 64'(cap_addr), 64'(ea));
            chk("R1 data", 64'(cap_data), 64'(ed));
        end else if (kind == 2) begin
            chk("R8 address", 64'(cap_addr), 64'(ea));
            chk("R9 data", 64'(cap_data), 64'(ed));
        end
        chk("R11 ready after completion", 64'(in_ready), 64'h1);
        inj = 0;
    endtask

    function automatic logic [31:0] rmp_addr(input logic [15:0] h, input bit sub);
        return 32'hFEE0_0000 | (32'(h[14:0]) << 5) | (32'(h[15]) << 2) | 32'h10 | (32'(sub) << 3);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < TBL_N; i++) begin
            tlo[i] = {$urandom(), $urandom()};
            tlo[i][0] = ($urandom % 4) != 0;
            thi[i] = {$urandom(), $urandom()};
        end
        tlo[5][0] = 1'b1;
        tlo[8][0] = 1'b1;
        tlo[9][0] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset ready", 64'(in_ready), 64'h1);
        chk("R12 reset out_valid", 64'(out_valid), 64'h0);
        chk("R12 reset mrd_valid", 64'(mrd_valid), 64'h0);
        chk("R12 reset err", 64'(err_pulse), 64'h0);

        cfg_tbl_base = 44'h12_3456_7890;
        cfg_count = 17'd32;
        // R1 disabled then outside window
        cfg_enable = 1'b0;
        run(rmp_addr(16'd5, 0), 32'hABCD_0001, 4'hF, thi[5][15:0]);
        cfg_enable = 1'b1;
        run(32'h1234_5678, 32'h0000_BEEF, 4'h3, 16'h0);
        // R2 partial strobes, R3 legacy format
        run(rmp_addr(16'd5, 0), 32'h0, 4'b0011, thi[5][15:0]);
        run(32'hFEE0_1000, 32'h41, 4'hF, 16'h0);
        // R4 boundary of count, subhandle, handle bit 15
        cfg_count = 17'd8;
        run(rmp_addr(16'd8, 0), 32'h0, 4'hF, thi[8][15:0]);
        run(rmp_addr(16'd5, 0), 32'h0, 4'hF, thi[5][15:0]);
        cfg_count = 17'd32;
        run(rmp_addr(16'd3, 1), 32'hFFFF_0005, 4'hF, thi[8][15:0]);
        run(rmp_addr(16'h8000, 0), 32'h0, 4'hF, 16'h0);
        cfg_count = 17'h10000;
        run(rmp_addr(16'h8000, 0), 32'h0, 4'hF, 16'h0);
        cfg_count = 17'd0;
        run(rmp_addr(16'd0, 0), 32'h0, 4'hF, thi[0][15:0]);
        cfg_count = 17'd32;
        // R6 not present, R7 source mismatch
        run(rmp_addr(16'd9, 0), 32'h0, 4'hF, thi[9][15:0]);
        run(rmp_addr(16'd5, 0), 32'h0, 4'hF, thi[5][15:0] ^ 16'h0100);
        // R10 response errors on each word
        inj = 1; run(rmp_addr(16'd5, 0), 32'h0, 4'hF, thi[5][15:0]);
        inj = 2; run(rmp_addr(16'd5, 0), 32'h0, 4'hF, thi[5][15:0]);
        // R11 backpressure on a remapped write
        bp_mode = 1;
        run(rmp_addr(16'd8, 0), 32'h0, 4'hF, thi[8][15:0]);

        for (int t = 0; t < 300; t++) begin
            int r;
            logic [15:0] h;
            bit sub;
            logic [31:0] a, d;
            logic [15:0] src;
            logic [3:0] s;
            bp_mode = ($urandom % 2) == 1;
            cfg_enable = ($urandom % 10) != 0;
            cfg_count = 17'(1 + $urandom % TBL_N);
            cfg_tbl_base = {$urandom(), 12'($urandom())};
            r = $urandom % 8;
            h = 16'($urandom % 40);
            sub = ($urandom % 2) == 1;
            d = $urandom();
            if (sub) d[15:0] = 16'($urandom % 8);
            a = rmp_addr(h, sub);
            s = 4'hF;
            if (r == 0) a = {12'h123, 20'($urandom())};
            else if (r == 1) a[4] = 1'b0;
            else if (r == 2) s = 4'($urandom % 15);
            src = 16'($urandom());
            if (($urandom % 4) != 0) src = entry_hi(int'({1'b0, h} + (sub ? {1'b0, d[15:0]} : 17'h0)))[15:0];
            inj = (($urandom % 10) == 0) ? int'(1 + $urandom % 2) : 0;
            run(a, d, s, src);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule